// File: doc/BRIEF.md
# E1 Primary-Rate Frame Multiplexer

This block builds a serial 2.048 Mbit/s primary-rate frame out of thirty byte-wide 64 kbit/s channels and one signalling byte. Every frame is 32 time slots of 8 bits each. One byte is taken from each channel per frame, in fixed round-robin order, and sent most significant bit first. The output moves one bit for each cycle in which the bit-rate clock enable is high. With the enable at 2.048 MHz, one frame lasts 125 µs, which gives 8000 frames per second.

Two slots never carry payload. Slot 0 holds the frame alignment word and the non-alignment word on alternate frames. Slot 16 carries the signalling byte. The thirty channels fill the other slots. Each channel has its own request strobe, so its source knows when its byte is about to be sampled. A frame-start marker shows where each frame begins on the line. Line coding, CRC-4, building the signalling multiframe and receive-side alignment are left to other blocks.

Top module: `e1_frame_mux`

## Requirements
- R1: A frame is 256 enabled bit periods long. `frameStart` is high exactly while bit 0 of slot 0 is on `serOut`, and it is low at every other bit position.
- R2: `serOut` advances by one bit only on a clock edge at which `bitEn` is high. Each slot byte is sent MSB first. While `bitEn` is low, `serOut` and `frameStart` hold their values.
- R3: Counting from reset, frames alternate even, odd, even, and so on, and the first frame after reset is even. In an even frame, slot 0 carries `{spareBit, 7'b0011011}`.
- R4: In an odd frame, slot 0 carries the non-alignment word `{spareBit, 1'b1, 6'b111111}`. Its second bit is 1.
- R5: Slot 16 carries `sigByte`. The value is sampled at the enabled edge that ends slot 15.
- R6: Channel n (0-based, 0..29) occupies slot n+1 for n ≤ 14 and slot n+2 for n ≥ 15. Its byte is `chanData[8n+7:8n]`, sampled at the enabled edge that ends the slot before.
- R7: `chanReq[n]` goes high for exactly one clock after the enabled edge that moves the line to bit 7 of the slot just before channel n's slot. At most one request bit is high at any time, and slots 0 and 16 produce no request. With `bitEn` high on every clock, the request comes one clock before the channel's slot begins.
- R8: A synchronous active-high `rst` returns the block to an even frame at slot 0, bit 0. After reset `frameStart` is high, `serOut` shows `spareBit`, and `chanReq` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bitEn | input | 1 | Bit-rate clock enable; one line bit per high cycle |
| spareBit | input | 1 | Value for bit 0 of slot 0 in every frame |
| sigByte | input | 8 | Signalling byte for slot 16 |
| chanData | input | 240 | Thirty channel bytes; channel n at bits 8n+7:8n |
| chanReq | output | 30 | Per-channel one-clock byte request strobes |
| serOut | output | 1 | Serial line output, MSB first |
| frameStart | output | 1 | High while slot 0 bit 0 is on the line |

## Verification
Each line bit appears on `serOut` one clock after the enabled edge that selects it, because it comes straight from the shift register. `frameStart` is decoded from the bit and slot counters, so it follows the same edge. A channel request appears one clock after the enabled edge that enters bit 7 of the slot before. The bench drives and samples only on the falling edge. At each falling edge it records the current `serOut` bit when the enable it is about to apply is high, and it compares `frameStart` and `chanReq` with the bit position it has recovered. Frames are rebuilt from the recovered stream and checked slot by slot. The stream is checked with the enable high on every clock and with the enable high one clock in three, and a check is also made after a reset in mid-frame.

// File: rtl/e1_mux_pkg.sv
package e1_mux_pkg;

  localparam int BYTE_W   = 8;
  localparam int CHAN_N   = 30;
  localparam int SLOT_N   = CHAN_N + 2;
  localparam int SLOT_W   = $clog2(SLOT_N);
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int SIG_SLOT = CHAN_N / 2 + 1;

  // Alignment word tail (bits 1..7 of slot 0, even frames)
  localparam logic [BYTE_W-2:0] ALIGN_TAIL = 7'b0011011;
  // Non-alignment word tail (bits 2..7 of slot 0, odd frames)
  localparam logic [BYTE_W-3:0] NFAS_TAIL  = 6'b111111;

  // Strobes from the slot controller to the datapath
  typedef struct packed {
    logic              loadSlot;  // enabled edge closes a slot
    logic              shiftBit;  // enabled edge moves to next bit
    logic [SLOT_W-1:0] nextSlot;  // slot that begins after loadSlot
    logic              nextOdd;   // parity of the frame owning nextSlot
  } ctrlStrobe_t;

  // 0-based channel index to time slot
  function automatic logic [SLOT_W-1:0] chanToSlot(input int chan);
    if (chan < SIG_SLOT - 1) return SLOT_W'(chan + 1);
    return SLOT_W'(chan + 2);
  endfunction

endpackage

// File: rtl/e1_slot_ctrl.sv
module e1_slot_ctrl
  import e1_mux_pkg::*;
#(
  parameter int NUM_CHAN = CHAN_N
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bitEn,
  output ctrlStrobe_t         strobe,
  output logic                frameStart,
  output logic [NUM_CHAN-1:0] chanReq
);

  localparam int NUM_SLOT = NUM_CHAN + 2;
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [BIT_W-1:0]  PRE_BIT  = BIT_W'(BYTE_W - 2);
  localparam logic [SLOT_W-1:0] LAST_SLT = SLOT_W'(NUM_SLOT - 1);

  logic [BIT_W-1:0]    bitCnt;
  logic [SLOT_W-1:0]   slotCnt;
  logic                oddFrame;
  logic                lastBit;
  logic                preLast;
  logic                lastSlot;
  logic [SLOT_W-1:0]   nextSlot;
  logic [NUM_CHAN-1:0] reqHit;

  assign lastBit  = (bitCnt == LAST_BIT);
  assign preLast  = (bitCnt == PRE_BIT);
  assign lastSlot = (slotCnt == LAST_SLT);
  assign nextSlot = lastSlot ? '0 : slotCnt + 1'b1;

  // One decode per channel: is its slot the next one to begin?
  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_reqDecode
    assign reqHit[g] = (nextSlot == chanToSlot(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt   <= '0;
      slotCnt  <= '0;
      oddFrame <= 1'b0;
      chanReq  <= '0;
    end else begin
      chanReq <= '0;
      if (bitEn) begin
        if (lastBit) begin
          bitCnt  <= '0;
          slotCnt <= nextSlot;
          if (lastSlot) oddFrame <= ~oddFrame;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
        if (preLast) chanReq <= reqHit;
      end
    end
  end

  always_comb begin
    strobe.loadSlot = bitEn && lastBit;
    strobe.shiftBit = bitEn && !lastBit;
    strobe.nextSlot = nextSlot;
    strobe.nextOdd  = lastSlot ? ~oddFrame : oddFrame;
  end

  assign frameStart = (slotCnt == '0) && (bitCnt == '0);

endmodule

// File: rtl/e1_slot_datapath.sv
module e1_slot_datapath
  import e1_mux_pkg::*;
#(
  parameter int NUM_CHAN = CHAN_N
) (
  input  logic                       clk,
  input  logic                       rst,
  input  ctrlStrobe_t                strobe,
  input  logic                       spareBit,
  input  logic [BYTE_W-1:0]          sigByte,
  input  logic [NUM_CHAN*BYTE_W-1:0] chanData,
  output logic                       serOut
);

  localparam logic [SLOT_W-1:0] SIG_IDX = SLOT_W'(SIG_SLOT);

  logic [BYTE_W-1:0] chanBytes [NUM_CHAN];
  logic [BYTE_W-1:0] payload;
  logic [BYTE_W-1:0] nextByte;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] alignWord;
  logic [BYTE_W-1:0] nfasWord;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_unpack
    assign chanBytes[g] = chanData[g*BYTE_W +: BYTE_W];
  end

  assign alignWord = {spareBit, ALIGN_TAIL};
  assign nfasWord  = {spareBit, 1'b1, NFAS_TAIL};

  // Payload select: one compare per channel against the next slot
  always_comb begin
    payload = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      if (strobe.nextSlot == chanToSlot(c)) payload = chanBytes[c];
    end
  end

  always_comb begin
    if (strobe.nextSlot == '0)
      nextByte = strobe.nextOdd ? nfasWord : alignWord;
    else if (strobe.nextSlot == SIG_IDX)
      nextByte = sigByte;
    else
      nextByte = payload;
  end

  always_ff @(posedge clk) begin
    if (rst)                  shiftReg <= alignWord;
    else if (strobe.loadSlot) shiftReg <= nextByte;
    else if (strobe.shiftBit) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
  end

  assign serOut = shiftReg[BYTE_W-1];

endmodule

// File: rtl/e1_frame_mux.sv
module e1_frame_mux
  import e1_mux_pkg::*;
#(
  parameter int NUM_CHAN = CHAN_N
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bitEn,
  input  logic                       spareBit,
  input  logic [BYTE_W-1:0]          sigByte,
  input  logic [NUM_CHAN*BYTE_W-1:0] chanData,
  output logic [NUM_CHAN-1:0]        chanReq,
  output logic                       serOut,
  output logic                       frameStart
);

  ctrlStrobe_t strobe;

  e1_slot_ctrl #(.NUM_CHAN(NUM_CHAN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bitEn     (bitEn),
    .strobe    (strobe),
    .frameStart(frameStart),
    .chanReq   (chanReq)
  );

  e1_slot_datapath #(.NUM_CHAN(NUM_CHAN)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .spareBit(spareBit),
    .sigByte (sigByte),
    .chanData(chanData),
    .serOut  (serOut)
  );

endmodule

// File: rtl/e1_frame_mux_chk.sv
module e1_frame_mux_chk #(
  parameter int NUM_CHAN = 30
) (
  input logic                clk,
  input logic                rst,
  input logic                bitEn,
  input logic [NUM_CHAN-1:0] chanReq,
  input logic                serOut,
  input logic                frameStart
);

  p_req_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chanReq));

  p_req_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (|chanReq) |=> (chanReq == '0));

  p_hold_ser_r2: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(serOut) && $stable(frameStart)));

  p_fs_short_r1: assert property (@(posedge clk) disable iff (rst)
    (frameStart && bitEn) |=> !frameStart);

  p_fs_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(frameStart) |-> $past(bitEn));

endmodule

bind e1_frame_mux e1_frame_mux_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bitEn     (bitEn),
  .chanReq   (chanReq),
  .serOut    (serOut),
  .frameStart(frameStart)
);

// File: tb/e1_frame_mux_tb.sv
module e1_frame_mux_tb;
  import e1_mux_pkg::*;

  localparam int NCH   = 30;
  localparam int FBITS = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bitEn = 1'b0;
  logic              spareBit = 1'b0;
  logic [7:0]        sigByte = '0;
  logic [NCH*8-1:0]  chanData = '0;
  logic [NCH-1:0]    chanReq;
  logic              serOut;
  logic              frameStart;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic capBits [2048];

  always #10 clk = ~clk;

  e1_frame_mux u_dut (
    .clk(clk), .rst(rst), .bitEn(bitEn), .spareBit(spareBit),
    .sigByte(sigByte), .chanData(chanData), .chanReq(chanReq),
    .serOut(serOut), .frameStart(frameStart)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] patByte(input int sel, input int k);
    if (sel == 0) return 8'(k * 37 + 11);
    return ~8'(k * 19 + 3);
  endfunction

  task automatic loadPattern(input int sel, input logic spare, input logic [7:0] sig);
    spareBit = spare;
    sigByte  = sig;
    for (int k = 0; k < NCH; k++) chanData[k*8 +: 8] = patByte(sel, k);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; bitEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Runs nBits enabled bits with the enable high one clock in 'period'.
  task automatic capture(input int nBits, input int period, input bit chkReq);
    int  pos = 0;
    int  cyc = 0;
    logic prevSer = 1'b0;
    bit  prevEn = 1'b0;
    int  holdBad = 0, fsBad = 0, reqBad = 0;
    while (pos < nBits) begin
      bit en;
      logic [NCH-1:0] reqExp;
      if (cyc > 0 && !prevEn && serOut !== prevSer) holdBad++;
      if (frameStart !== ((pos % FBITS) == 0)) fsBad++;
      reqExp = '0;
      if (chkReq)
        for (int k = 0; k < NCH; k++)
          reqExp[k] = ((pos % FBITS) == int'(chanToSlot(k)) * 8 - 1);
      if (chkReq && chanReq !== reqExp) reqBad++;
      en = ((cyc % period) == 0);
      if (en) begin
        capBits[pos] = serOut;
        pos++;
      end
      bitEn   = en;
      prevSer = serOut;
      prevEn  = en;
      cyc++;
      @(negedge clk);
    end
    bitEn = 1'b0;
    check(holdBad == 0, "R2", "serOut changed with bitEn low (count)", holdBad, 0);
    check(fsBad == 0, "R1", "frameStart position mismatches (count)", fsBad, 0);
    if (chkReq) check(reqBad == 0, "R7", "chanReq timing mismatches (count)", reqBad, 0);
  endtask

  function automatic logic [7:0] capByte(input int f, input int s);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = capBits[f*FBITS + s*8 + i];
    return b;
  endfunction

  task automatic checkFrames(input int nFrames, input int sel);
    for (int f = 0; f < nFrames; f++) begin
      logic [7:0] w0 = capByte(f, 0);
      if ((f % 2) == 0)
        check(w0 === {spareBit, 7'b0011011}, "R3", $sformatf("frame %0d alignment word", f),
              w0, {spareBit, 7'b0011011});
      else
        check(w0 === {spareBit, 1'b1, 6'b111111}, "R4", $sformatf("frame %0d non-alignment word", f),
              w0, {spareBit, 1'b1, 6'b111111});
      check(capByte(f, 16) === sigByte, "R5", $sformatf("frame %0d slot 16", f),
            capByte(f, 16), sigByte);
      for (int k = 0; k < NCH; k++) begin
        int s = (k <= 14) ? k + 1 : k + 2;
        check(capByte(f, s) === patByte(sel, k), "R6",
              $sformatf("frame %0d channel %0d slot %0d", f, k, s),
              capByte(f, s), patByte(sel, k));
      end
    end
  endtask

  task automatic testReset();
    loadPattern(0, 1'b1, 8'hA5);
    doReset();
    check(frameStart === 1'b1, "R8", "frameStart after reset", frameStart, 1);
    check(serOut === 1'b1, "R8", "serOut shows spareBit after reset", serOut, 1);
    check(chanReq === '0, "R8", "chanReq clear after reset", int'(|chanReq), 0);
  endtask

  task automatic testContinuous();
    loadPattern(0, 1'b1, 8'hA5);
    doReset();
    capture(4 * FBITS, 1, 1'b1);
    checkFrames(4, 0);
  endtask

  task automatic testSparseEnable();
    loadPattern(1, 1'b0, 8'h3C);
    doReset();
    capture(4 * FBITS, 3, 1'b0);
    checkFrames(4, 1);
  endtask

  task automatic testMidReset();
    loadPattern(0, 1'b0, 8'h5A);
    doReset();
    capture(300, 1, 1'b0);
    doReset();
    check(frameStart === 1'b1, "R8", "frameStart after mid-frame reset", frameStart, 1);
    capture(FBITS, 1, 1'b1);
    checkFrames(1, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testContinuous();
    testSparseEnable();
    testMidReset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule